// File: doc/BRIEF.md
# Single-Correct Double-Detect Block Decoder with Sample Concealment

This block receives 63-bit systematic block codewords, one per input strobe, each carrying a 56-bit signed sample and seven check bits. A parallel syndrome is formed in one cycle. If the syndrome points at one bit position, that bit is flipped back. Any other nonzero syndrome marks the word as carrying two errors. The code does not repair such a word.

A word that cannot be repaired is replaced at the output. In hold mode the replacement is the sample most recently emitted. In interpolation mode it is the floored mean of that sample and the next word's decoded sample, as long as the next word is itself usable. Each sample therefore leaves the block only once its successor has been decoded. The output strobe always comes a fixed number of cycles after an input strobe and carries the word that came before. Two flags travel with each output sample: one for a repaired single error and one for a concealed double error.

Top module: `bchConceal`

## Requirements
- R1: A codeword holds the sample in bits [62:7] and the check bits in [6:0]. The check bits are the remainder of (sample times x^7) divided by the generator x^7+x^6+x^2+1, where bit i stands for x^i.
- R2: A codeword with no error is emitted with its sample unchanged and with both flags low.
- R3: A codeword with exactly one flipped bit, at any of positions 0 to 62, is emitted with its original sample and with outSingleErr high and outDoubleErr low.
- R4: A codeword with exactly two flipped bits is emitted with outDoubleErr high and outSingleErr low, and its sample is concealed.
- R5: In hold mode (concealMode = 0) a concealed sample equals the sample emitted just before it. The first emitted sample after reset takes 0 as its previous sample.
- R6: In interpolation mode (concealMode = 1) a concealed sample is floor((prev + next) / 2). Here prev is the sample emitted just before it, next is the decoded sample of the following codeword, and both are 56-bit two's complement values. A single error in the following codeword is repaired before it is used.
- R7: In interpolation mode, if the following codeword also has two errors, the concealed sample falls back to the hold value.
- R8: An input strobe sampled at clock edge n produces a one-cycle outValid pulse after edge n+1, if an earlier word is pending. That pulse carries the earlier word. The first word after reset produces no output, and back-to-back strobes are accepted.
- R9: While rstN is low, outValid, outData and both flags are held at zero.
- R10: The mode used to conceal a word is the value of concealMode at the edge where that word is emitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Codeword strobe |
| inCode | input | 63 | Received codeword |
| concealMode | input | 1 | 0 = hold previous sample, 1 = interpolate |
| outValid | output | 1 | Output sample strobe |
| outData | output | 56 | Decoded or concealed sample |
| outSingleErr | output | 1 | Sample had one error that was repaired |
| outDoubleErr | output | 1 | Sample had two errors and was concealed |

## Verification
Two functions can act in the same cycle: emitting a concealed word, and repairing the word that follows it. In interpolation mode the mean uses the follower's decoded sample, so both happen at one clock edge. The bench sends a two-error word directly followed by a one-error word. It judges the output by comparing the concealed sample against the mean built from the follower's clean value, and checks that the follower comes out next with only the single flag set. Negative samples and a following word with two errors are also covered, to test floor rounding and the fallback to hold.

// File: rtl/bchConcealPkg.sv
package bchConcealPkg;

  typedef enum logic [1:0] {
    SEL_PASS = 2'd0,
    SEL_HOLD = 2'd1,
    SEL_MEAN = 2'd2
  } concealSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic        capture;  // latch incoming codeword
    logic        load;     // move decoded word into pending slot
    logic        emit;     // release the pending word to the output
    concealSel_e sel;      // how the pending word is rendered
  } dpStrobes_t;

endpackage

// File: rtl/bchLocator.sv
module bchLocator #(
  parameter int N = 63,
  parameter int K = 56,
  parameter logic [N-K:0] GEN_POLY = 'hC5
) (
  input  logic [N-1:0] code,
  output logic [N-1:0] errVec,
  output logic         synNonzero
);
  localparam int P = N - K;

  // remainder of v(x) divided by the generator, bits shifted in msb first
  function automatic logic [P-1:0] polyRem(input logic [N-1:0] v);
    logic [P-1:0] r;
    logic         fb;
    r = '0;
    for (int i = N - 1; i >= 0; i--) begin
      fb = r[P-1];
      r  = {r[P-2:0], v[i]};
      if (fb) r = r ^ GEN_POLY[P-1:0];
    end
    return r;
  endfunction

  function automatic logic [P-1:0] posRem(input int pos);
    logic [N-1:0] v;
    v      = '0;
    v[pos] = 1'b1;
    return polyRem(v);
  endfunction

  logic [P-1:0] syn;
  assign syn        = polyRem(code);
  assign synNonzero = |syn;

  // one comparator per bit position; each position has a distinct syndrome
  for (genvar i = 0; i < N; i++) begin : gPos
    localparam logic [P-1:0] POS_SYN = posRem(i);
    assign errVec[i] = (syn == POS_SYN);
  end

endmodule

// File: rtl/bchControl.sv
module bchControl
  import bchConcealPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       concealMode,
  input  logic       pendDouble,
  input  logic       nextDouble,
  output dpStrobes_t strobes
);
  logic s1Valid;
  logic havePending;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1Valid     <= 1'b0;
      havePending <= 1'b0;
    end else begin
      s1Valid <= inValid;
      if (s1Valid) havePending <= 1'b1;
    end
  end

  always_comb begin
    strobes.capture = inValid;
    strobes.load    = s1Valid;
    strobes.emit    = s1Valid & havePending;
    if (!pendDouble)
      strobes.sel = SEL_PASS;
    else if (concealMode && !nextDouble)
      strobes.sel = SEL_MEAN;
    else
      strobes.sel = SEL_HOLD;
  end

endmodule

// File: rtl/bchDatapath.sv
module bchDatapath
  import bchConcealPkg::*;
#(
  parameter int N = 63,
  parameter int K = 56,
  parameter logic [N-K:0] GEN_POLY = 'hC5
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [N-1:0] inCode,
  input  dpStrobes_t   strobes,
  output logic         pendDouble,
  output logic         nextDouble,
  output logic         outValid,
  output logic [K-1:0] outData,
  output logic         outSingleErr,
  output logic         outDoubleErr
);
  localparam int P = N - K;

  logic [N-1:0] s1Code;
  logic [N-1:0] errVec;
  logic         synNonzero;
  logic [K-1:0] decData;
  logic         decSingle;
  logic [K-1:0] pendData;
  logic         pendSingle;
  logic signed [K:0] sumWide;
  logic [K-1:0] meanData;

  bchLocator #(.N(N), .K(K), .GEN_POLY(GEN_POLY)) uLoc (
    .code      (s1Code),
    .errVec    (errVec),
    .synNonzero(synNonzero)
  );

  assign decSingle  = |errVec;
  assign nextDouble = synNonzero & ~decSingle;
  assign decData    = s1Code[N-1:P] ^ errVec[N-1:P];

  // outData doubles as the previous emitted sample
  assign sumWide  = $signed({outData[K-1], outData}) + $signed({decData[K-1], decData});
  assign meanData = sumWide[K:1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1Code <= '0;
    end else if (strobes.capture) begin
      s1Code <= inCode;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendData   <= '0;
      pendSingle <= 1'b0;
      pendDouble <= 1'b0;
    end else if (strobes.load) begin
      pendData   <= decData;
      pendSingle <= decSingle;
      pendDouble <= nextDouble;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid     <= 1'b0;
      outData      <= '0;
      outSingleErr <= 1'b0;
      outDoubleErr <= 1'b0;
    end else if (strobes.emit) begin
      outValid     <= 1'b1;
      outSingleErr <= pendSingle;
      outDoubleErr <= pendDouble;
      case (strobes.sel)
        SEL_PASS: outData <= pendData;
        SEL_MEAN: outData <= meanData;
        default:  outData <= outData;
      endcase
    end else begin
      outValid     <= 1'b0;
      outSingleErr <= 1'b0;
      outDoubleErr <= 1'b0;
    end
  end

endmodule

// File: rtl/bchConceal.sv
module bchConceal
  import bchConcealPkg::*;
#(
  parameter int N = 63,
  parameter int K = 56,
  parameter logic [N-K:0] GEN_POLY = 'hC5
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  input  logic [N-1:0] inCode,
  input  logic         concealMode,
  output logic         outValid,
  output logic [K-1:0] outData,
  output logic         outSingleErr,
  output logic         outDoubleErr
);
  dpStrobes_t strobes;
  logic       pendDouble;
  logic       nextDouble;

  bchControl uCtl (
    .clk        (clk),
    .rstN       (rstN),
    .inValid    (inValid),
    .concealMode(concealMode),
    .pendDouble (pendDouble),
    .nextDouble (nextDouble),
    .strobes    (strobes)
  );

  bchDatapath #(.N(N), .K(K), .GEN_POLY(GEN_POLY)) uDp (
    .clk         (clk),
    .rstN        (rstN),
    .inCode      (inCode),
    .strobes     (strobes),
    .pendDouble  (pendDouble),
    .nextDouble  (nextDouble),
    .outValid    (outValid),
    .outData     (outData),
    .outSingleErr(outSingleErr),
    .outDoubleErr(outDoubleErr)
  );

endmodule

// File: rtl/bchConcealChecker.sv
module bchConcealChecker #(
  parameter int K = 56
) (
  input logic         clk,
  input logic         rstN,
  input logic         inValid,
  input logic         concealMode,
  input logic         outValid,
  input logic [K-1:0] outData,
  input logic         outSingleErr,
  input logic         outDoubleErr
);

  // R8: every output pulse answers an input strobe two edges earlier
  a_r8_out_after_in: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(inValid, 2));

  // R8: output sample holds between pulses
  a_r8_data_stable_idle: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> $stable(outData));

  // R3 / R4: a word is either repaired or concealed, never both
  a_r4_flags_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({outSingleErr, outDoubleErr}));

  // R2: flags only accompany an output pulse
  a_r2_flags_need_valid: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> !outSingleErr && !outDoubleErr);

  // R5 / R10: hold mode repeats the previous sample
  a_r5_hold_repeats: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outDoubleErr && !$past(concealMode)) |-> outData == $past(outData));

  // R9: reset clears the output strobe
  a_r9_reset_quiet: assert property (@(posedge clk)
    !rstN |=> !outValid);

endmodule

bind bchConceal bchConcealChecker #(.K(K)) chk (
  .clk         (clk),
  .rstN        (rstN),
  .inValid     (inValid),
  .concealMode (concealMode),
  .outValid    (outValid),
  .outData     (outData),
  .outSingleErr(outSingleErr),
  .outDoubleErr(outDoubleErr)
);

// File: tb/bchConceal_test.sv
module bchConceal_test;
  localparam int CLK_PERIOD = 10;
  localparam int N = 63;
  localparam int K = 56;
  localparam int MAXW = 16;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         inValid = 1'b0;
  logic [N-1:0] inCode = '0;
  logic         concealMode = 1'b0;
  logic         outValid;
  logic [K-1:0] outData;
  logic         outSingleErr;
  logic         outDoubleErr;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  bchConceal uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inCode(inCode),
    .concealMode(concealMode), .outValid(outValid), .outData(outData),
    .outSingleErr(outSingleErr), .outDoubleErr(outDoubleErr)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  // stimulus words and their injected flips (-1 = none)
  logic [K-1:0] wData [MAXW];
  int           wFlipA[MAXW];
  int           wFlipB[MAXW];

  // captured outputs
  logic [K-1:0] gotData [32];
  logic         gotS    [32];
  logic         gotD    [32];
  int           nOut = 0;

  always @(negedge clk) begin
    if (outValid && nOut < 32) begin
      gotData[nOut] = outData;
      gotS[nOut]    = outSingleErr;
      gotD[nOut]    = outDoubleErr;
      nOut++;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // R1: remainder by x^7+x^6+x^2+1, msb first
  function automatic logic [6:0] rem7(input logic [N-1:0] v);
    logic [6:0] r;
    logic fb;
    r = '0;
    for (int i = N - 1; i >= 0; i--) begin
      fb = r[6];
      r  = {r[5:0], v[i]};
      if (fb) r = r ^ 7'h45;
    end
    return r;
  endfunction

  function automatic logic [N-1:0] encode(input logic [K-1:0] d);
    return {d, rem7({d, 7'b0})};
  endfunction

  function automatic logic [K-1:0] meanOf(input logic [K-1:0] a, input logic [K-1:0] b);
    longint sa, sb, m;
    sa = longint'({{8{a[K-1]}}, a});
    sb = longint'({{8{b[K-1]}}, b});
    m  = (sa + sb) >>> 1;
    return m[K-1:0];
  endfunction

  function automatic logic [K-1:0] rnd56();
    logic [63:0] r;
    r = {$urandom, $urandom};
    return r[K-1:0];
  endfunction

  task automatic resetDut();
    @(negedge clk);
    rstN = 1'b0;
    inValid = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    nOut = 0;
  endtask

  task automatic fillRandom(input int n);
    for (int k = 0; k < n; k++) begin
      wData[k]  = rnd56();
      wFlipA[k] = -1;
      wFlipB[k] = -1;
    end
  endtask

  // sends n words plus a clean flush word, then compares n outputs
  task automatic runCase(input string req, input int n, input bit mode, input bit gap);
    logic [K-1:0] prev, expD;
    int kindK, kindN;
    logic [N-1:0] c;
    resetDut();
    concealMode = mode;
    wData[n]  = rnd56();
    wFlipA[n] = -1;
    wFlipB[n] = -1;
    for (int k = 0; k <= n; k++) begin
      @(negedge clk);
      c = encode(wData[k]);
      if (wFlipA[k] >= 0) c[wFlipA[k]] = ~c[wFlipA[k]];
      if (wFlipB[k] >= 0) c[wFlipB[k]] = ~c[wFlipB[k]];
      inValid = 1'b1;
      inCode  = c;
      if (gap) begin
        @(negedge clk);
        inValid = 1'b0;
      end
    end
    @(negedge clk);
    inValid = 1'b0;
    repeat (4) @(negedge clk);
    check(nOut == n, req, "output count", 64'(nOut), 64'(n));
    prev = '0;
    for (int k = 0; k < n && k < nOut; k++) begin
      kindK = (wFlipA[k] >= 0 ? 1 : 0) + (wFlipB[k] >= 0 ? 1 : 0);
      kindN = (wFlipA[k+1] >= 0 ? 1 : 0) + (wFlipB[k+1] >= 0 ? 1 : 0);
      if (kindK < 2)        expD = wData[k];
      else if (!mode)       expD = prev;
      else if (kindN < 2)   expD = meanOf(prev, wData[k+1]);
      else                  expD = prev;
      check(gotData[k] == expD, req, $sformatf("data word %0d", k), 64'(gotData[k]), 64'(expD));
      check(gotS[k] == (kindK == 1), req, $sformatf("single flag word %0d", k),
            64'(gotS[k]), 64'(kindK == 1));
      check(gotD[k] == (kindK == 2), req, $sformatf("double flag word %0d", k),
            64'(gotD[k]), 64'(kindK == 2));
      prev = expD;
    end
  endtask

  task automatic testReset();
    // R9
    @(negedge clk);
    check(!outValid && outData == '0 && !outSingleErr && !outDoubleErr, "R9",
          "reset outputs", {outValid, outSingleErr, outDoubleErr, 5'b0, outData}, 64'h0);
  endtask

  task automatic testClean();
    // R1, R2: clean words, both gapped and back-to-back
    fillRandom(6);
    runCase("R1_R2", 6, 1'b0, 1'b1);
    fillRandom(6);
    runCase("R2", 6, 1'b1, 1'b0);
  endtask

  task automatic testSingle();
    // R3: single flips at data, check and boundary positions
    fillRandom(8);
    wFlipA[0] = 0;
    wFlipA[1] = 62;
    wFlipA[2] = 6;
    wFlipA[3] = 7;
    wFlipA[5] = 33;
    wFlipA[6] = 1;
    runCase("R3", 8, 1'b0, 1'b0);
  endtask

  task automatic testHold();
    // R4, R5: first word bad (prev 0), then runs of bad words
    fillRandom(7);
    wFlipA[0] = 3;  wFlipB[0] = 40;
    wFlipA[2] = 62; wFlipB[2] = 0;
    wFlipA[3] = 10; wFlipB[3] = 11;
    wFlipA[5] = 7;  wFlipB[5] = 50;
    runCase("R4_R5", 7, 1'b0, 1'b1);
  endtask

  task automatic testInterp();
    // R6: negative samples exercise floor rounding; R6 also repairs the follower
    fillRandom(6);
    wData[0] = -56'sd5;
    wFlipA[1] = 20; wFlipB[1] = 44;
    wData[2] = 56'd2;
    wData[3] = 56'd100;
    wFlipA[4] = 9;  wFlipB[4] = 60;
    wFlipA[5] = 15;            // follower of a concealed word carries one error
    runCase("R6", 6, 1'b1, 1'b0);
  endtask

  task automatic testInterpFallback();
    // R7: two bad words in a row in interpolation mode
    fillRandom(6);
    wFlipA[1] = 2;  wFlipB[1] = 30;
    wFlipA[2] = 8;  wFlipB[2] = 61;
    wFlipA[3] = 12; wFlipB[3] = 13;
    runCase("R7", 6, 1'b1, 1'b1);
  endtask

  task automatic testTiming();
    logic [K-1:0] a, b;
    // R8: exact pulse cycle, back-to-back acceptance; R10: mode at emission edge
    resetDut();
    a = rnd56();
    b = rnd56();
    concealMode = 1'b1;
    @(negedge clk);
    inValid = 1'b1; inCode = encode(a);
    @(negedge clk);
    check(!outValid, "R8", "no output after first word", 64'(outValid), 64'h0);
    inValid = 1'b1; inCode = encode(b) ^ (63'h3 << 20);
    @(negedge clk);
    check(!outValid, "R8", "first word still pending", 64'(outValid), 64'h0);
    inValid = 1'b0;
    @(negedge clk);
    check(outValid && outData == a, "R8", "pulse carries first word", 64'(outData), 64'(a));
    // next word makes the bad one emit; switch mode to hold just before
    concealMode = 1'b0;
    inValid = 1'b1; inCode = encode(rnd56());
    @(negedge clk);
    check(!outValid, "R8", "pulse lasts one cycle", 64'(outValid), 64'h0);
    inValid = 1'b0;
    @(negedge clk);
    check(outValid && outDoubleErr && outData == a, "R10", "hold used at emit edge",
          64'(outData), 64'(a));
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    testReset();
    rstN = 1'b1;
    testClean();
    testSingle();
    testHold();
    testInterp();
    testInterpFallback();
    testTiming();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule